// File: doc/BRIEF.md
# SDRAM Single-Burst Command Sequencer

This block turns one memory request at a time into the command sequence for a two-bank SDRAM whose mode register has already been loaded. A request names the direction, the bank, the row and the starting column. A write request also carries one data word per beat, and every request carries a per-beat mask. The block opens the row and waits out the row-to-column delay. It then issues one burst read or burst write, with auto-precharge disabled. The burst is ended with an explicit burst stop, followed by a precharge of the same bank. The block then waits out the precharge time before it takes another request.

On writes the block drives the data bus from the command cycle onward, and the mask bits drive DQM in the same cycle as the beat they mask. On reads, DQM reaches the pins two cycles ahead of the beat it suppresses. The block captures unmasked beats CAS-latency cycles after the command and delivers them on a valid-qualified read port. Burst length, CAS latency, row-to-column delay and precharge time are parameters, and they must agree with the opcode already in the mode register.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, req_ready is high, the command is NOP (cs_n low; ras_n, cas_n and we_n high), sd_addr is zero, and sd_dq_oe, sd_dqm and rd_valid are low.
- R2: When a request is accepted (req_valid and req_ready high at a clock edge), the next cycle carries bank activate: cs_n and ras_n low, cas_n and we_n high, the row on sd_addr[10:0] and the bank on sd_addr[11]. req_ready is low from that cycle onward.
- R3: The read command (cs_n and cas_n low; ras_n and we_n high) or the write command (cs_n, cas_n and we_n low; ras_n high) comes exactly TRCD cycles after the activate cycle. It carries the column on the low address bits, with sd_addr[10] low and the bank on sd_addr[11].
- R4: On a write, beat i (bits i*DATA_W upward of req_wdata) appears on sd_dq_o with sd_dq_oe high in cycle W+i, where W is the write command cycle. sd_dq_oe is low in every other cycle.
- R5: On a write, sd_dqm in cycle W+i equals req_mask[i] (1 means masked).
- R6: On a read issued in cycle R, the bus is sampled at the end of cycle R+CL+i for beat i. If req_mask[i] is 0, that value appears on rd_data with rd_valid high in cycle R+CL+i+1. A masked beat produces no rd_valid.
- R7: On a read, sd_dqm in cycle R+CL+i-2 equals req_mask[i]. sd_dqm is low in every other cycle of a read.
- R8: Burst stop (cs_n and we_n low; ras_n and cas_n high) comes BL cycles after the read or write command. Precharge (cs_n, ras_n and we_n low, cas_n high) follows in the next cycle, with sd_addr[10] low and the bank on sd_addr[11].
- R9: Every other cycle is a NOP with sd_addr zero. req_ready goes high again TRP cycles after the precharge cycle.
- R10: A req_valid held high while req_ready is low starts nothing. The command sequence of the transfer in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 1 | Bank select |
| req_row | input | ADDR_W-1 | Row address |
| req_col | input | COL_W | Starting column |
| req_wdata | input | BL*DATA_W | Write beats, beat 0 in the low bits |
| req_mask | input | BL | Per-beat mask, bit i masks beat i |
| rd_valid | output | 1 | rd_data holds an unmasked read beat |
| rd_data | output | DATA_W | Captured read beat |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus; bit 11 bank, bit 10 auto-precharge flag |
| sd_dqm | output | 1 | Data mask |
| sd_dq_o | output | DATA_W | Data driven onto the bus |
| sd_dq_oe | output | 1 | Bus drive enable; the bus floats when low |
| sd_dq_i | input | DATA_W | Data sampled from the bus |

## Verification
The hardest case to reach is a read whose mask is sparse. Here the DQM edge must lead the affected data by two cycles, while rd_valid must skip exactly the masked beats one cycle after sampling, so two timings offset from each other must both hold. The bench acts as the memory: it drives a computed value onto the read bus in exactly the cycle where each beat belongs, and junk in every other cycle. It sweeps all sixteen masks in both directions, with requests issued back to back. It also holds req_valid high with unrelated fields while the block is busy, so that any early acceptance would show up as a stray command.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int BL     = 4,
  parameter int CL     = 2,
  parameter int TRCD   = 2,
  parameter int TRP    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_bank,
  input  logic [ADDR_W-2:0]    req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic [BL*DATA_W-1:0] req_wdata,
  input  logic [BL-1:0]        req_mask,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [ADDR_W-1:0]    sd_addr,
  output logic                 sd_dqm,
  output logic [DATA_W-1:0]    sd_dq_o,
  output logic                 sd_dq_oe,
  input  logic [DATA_W-1:0]    sd_dq_i
);
  localparam int ROW_W  = ADDR_W - 1;
  localparam int AP_BIT = 10;
  localparam int BW     = (BL > 1) ? $clog2(BL) : 1;
  localparam int CNT_W  = $clog2(TRCD + TRP + BL + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_RCD, S_RW, S_STOP, S_PRE, S_REC} state_t;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_BST = 4'b0110;
  localparam logic [3:0] C_PRE = 4'b0010;

  state_t               state;
  logic [CNT_W-1:0]     cnt;
  logic                 wr_q, bank_q;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic [BL*DATA_W-1:0] wdata_q;
  logic [BL-1:0]        mask_q;
  logic [BW-1:0]        beat;
  logic [3:0]           cmd;
  logic                 in_rw, rd_mask_now, rd_take_now, rd_dqm;
  logic [CL-1:0]        rpipe;

  assign req_ready = (state == S_IDLE);
  assign beat      = cnt[BW-1:0];
  assign in_rw     = (state == S_RW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      bank_q  <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state   <= S_ACT;
          wr_q    <= req_write;
          bank_q  <= req_bank;
          row_q   <= req_row;
          col_q   <= req_col;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
        end
        S_ACT: begin
          cnt   <= (TRCD > 1) ? CNT_W'(TRCD - 1) : '0;
          state <= (TRCD > 1) ? S_RCD : S_RW;
        end
        S_RCD: begin
          if (cnt == CNT_W'(1)) begin
            cnt   <= '0;
            state <= S_RW;
          end else cnt <= cnt - 1'b1;
        end
        S_RW: begin
          if (cnt == CNT_W'(BL - 1)) begin
            cnt   <= '0;
            state <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: state <= S_PRE;
        S_PRE: begin
          cnt   <= (TRP > 1) ? CNT_W'(TRP - 1) : '0;
          state <= (TRP > 1) ? S_REC : S_IDLE;
        end
        S_REC: begin
          if (cnt == CNT_W'(1)) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd     = C_NOP;
    sd_addr = '0;
    case (state)
      S_ACT: begin
        cmd     = C_ACT;
        sd_addr = {bank_q, row_q};
      end
      S_RW: if (cnt == '0) begin
        cmd                 = wr_q ? C_WR : C_RD;
        sd_addr[COL_W-1:0]  = col_q;
        sd_addr[AP_BIT]     = 1'b0;
        sd_addr[ADDR_W-1]   = bank_q;
      end
      S_STOP: cmd = C_BST;
      S_PRE: begin
        cmd               = C_PRE;
        sd_addr[ADDR_W-1] = bank_q;
      end
      default: ;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  assign sd_dq_oe = in_rw && wr_q;
  assign sd_dq_o  = sd_dq_oe ? wdata_q[beat*DATA_W +: DATA_W] : '0;

  assign rd_mask_now = in_rw && !wr_q && mask_q[beat];
  assign rd_take_now = in_rw && !wr_q && !mask_q[beat];

  generate
    if (CL == 2) begin : g_dqm_now
      assign rd_dqm = rd_mask_now;
    end else begin : g_dqm_dly
      logic [CL-3:0] mpipe;
      always_ff @(posedge clk) begin
        if (!rst_n) mpipe <= '0;
        else begin
          mpipe[0] <= rd_mask_now;
          for (int i = 1; i < CL - 2; i++) mpipe[i] <= mpipe[i-1];
        end
      end
      assign rd_dqm = mpipe[CL-3];
    end
  endgenerate

  assign sd_dqm = (sd_dq_oe && mask_q[beat]) || rd_dqm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpipe    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rpipe[0] <= rd_take_now;
      for (int i = 1; i < CL; i++) rpipe[i] <= rpipe[i-1];
      rd_valid <= rpipe[CL-1];
      if (rpipe[CL-1]) rd_data <= sd_dq_i;
    end
  end
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int BL     = 4,
  parameter int TRCD   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              sd_dq_oe
);
  logic [3:0] c;
  logic       is_act, is_rw, is_wr, is_bst, is_pre;
  logic [7:0] since_act, since_rw;
  logic       act_bank;

  assign c      = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign is_act = (c == 4'b0011);
  assign is_wr  = (c == 4'b0100);
  assign is_rw  = is_wr || (c == 4'b0101);
  assign is_bst = (c == 4'b0110);
  assign is_pre = (c == 4'b0010);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= 8'hff;
      since_rw  <= 8'hff;
      act_bank  <= 1'b0;
    end else begin
      if (is_act) begin
        since_act <= 8'd1;
        act_bank  <= sd_addr[ADDR_W-1];
      end else if (since_act != 8'hff) since_act <= since_act + 8'd1;
      if (is_rw) since_rw <= 8'd1;
      else if (since_rw != 8'hff) since_rw <= since_rw + 8'd1;
    end
  end

  assert_accept_activates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (is_act && !req_ready));
  assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act == 8'(TRCD)));
  assert_oe_starts_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_dq_oe) |-> is_wr);
  assert_no_autopre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw || is_pre) |-> !sd_addr[10]);
  assert_stop_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_bst |-> (since_rw == 8'(BL)));
  assert_pre_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> $past(is_bst));
  assert_pre_same_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (sd_addr[ADDR_W-1] == act_bank));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.ADDR_W(ADDR_W), .BL(BL), .TRCD(TRCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
  .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe)
);

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;
  localparam int DW = 8, AW = 12, CW = 9, BL = 4, CL = 2, TRCD = 2, TRP = 2;
  localparam int RW   = 1 + TRCD;
  localparam int CEND = RW + BL + 1 + TRP;
  localparam int CLST = (CEND > RW + CL + BL) ? CEND : RW + CL + BL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_bank = 1'b0;
  logic [AW-2:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [BL*DW-1:0] req_wdata = '0;
  logic [BL-1:0] req_mask = '0;
  logic [DW-1:0] sd_dq_i = 8'hA5;
  wire req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  wire [DW-1:0] rd_data, sd_dq_o;
  wire [AW-1:0] sd_addr;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  sdram_burst_seq #(.DATA_W(DW), .ADDR_W(AW), .COL_W(CW), .BL(BL), .CL(CL),
                    .TRCD(TRCD), .TRP(TRP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe),
    .sd_dq_i(sd_dq_i));

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rpat(input logic [AW-2:0] row, input logic [CW-1:0] col, input int k);
    return DW'(row * 3 + col + k * 17);
  endfunction

  task automatic run_req(input logic wr, input logic bank, input logic [AW-2:0] row,
                         input logic [CW-1:0] col, input logic [BL*DW-1:0] wd, input logic [BL-1:0] m);
    logic [15:0] exp_ca;
    logic [AW-1:0] ea;
    logic [3:0] ec;
    string tag;
    req_valid = 1'b1; req_write = wr; req_bank = bank; req_row = row;
    req_col = col; req_wdata = wd; req_mask = m;
    @(posedge clk);
    for (int c = 1; c <= CLST; c++) begin
      @(negedge clk);
      // R10: hold valid with unrelated fields while busy
      if (c <= CEND - 2) begin
        req_valid = 1'b1; req_write = ~wr; req_bank = ~bank; req_row = ~row;
        req_col = ~col; req_mask = ~m;
      end else req_valid = 1'b0;
      sd_dq_i = 8'hA5;
      if (!wr && c >= RW + CL && c < RW + CL + BL) sd_dq_i = rpat(row, col, c - RW - CL);
      ec = 4'b0111; ea = '0; tag = "R9";
      if (c == 1) begin ec = 4'b0011; ea = {bank, row}; tag = "R2"; end
      else if (c == RW) begin
        ec = wr ? 4'b0100 : 4'b0101; ea = {bank, 1'b0, (AW-2-CW)'(0), col}; tag = "R3";
      end
      else if (c == RW + BL) begin ec = 4'b0110; tag = "R8"; end
      else if (c == RW + BL + 1) begin ec = 4'b0010; ea = {bank, (AW-1)'(0)}; tag = "R8"; end
      exp_ca = {ec, ea};
      chk(tag, "cmd/addr (R10 busy valid)", 64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr}), 64'(exp_ca));
      chk("R9", "req_ready", 64'(req_ready), 64'(c >= CEND));
      if (wr && c >= RW && c < RW + BL) begin
        chk("R4", "write beat oe/data", 64'({sd_dq_oe, sd_dq_o}), 64'({1'b1, wd[(c-RW)*DW +: DW]}));
        chk("R5", "write dqm", 64'(sd_dqm), 64'(m[c-RW]));
      end else begin
        chk("R4", "oe idle", 64'(sd_dq_oe), 64'(0));
        if (!wr && c >= RW + CL - 2 && c < RW + CL - 2 + BL)
          chk("R7", "read dqm", 64'(sd_dqm), 64'(m[c-(RW+CL-2)]));
        else chk("R7", "dqm idle", 64'(sd_dqm), 64'(0));
      end
      if (!wr && c >= RW + CL + 1 && c < RW + CL + 1 + BL && !m[c-(RW+CL+1)])
        chk("R6", "read beat", 64'({rd_valid, rd_data}), 64'({1'b1, rpat(row, col, c - (RW+CL+1))}));
      else chk("R6", "rd_valid", 64'(rd_valid), 64'(0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "idle pins", 64'({req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr, sd_dq_oe, sd_dqm, rd_valid}),
        64'({1'b1, 4'b0111, {AW{1'b0}}, 3'b000}));
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < (1 << BL); m++)
        run_req(w[0], m[0] ^ w[0], (AW-1)'(m * 97 + w * 1000 + 5), CW'(m * 29 + 3),
                {BL{8'(m * 13 + w)}} ^ 32'h0102_0304, BL'(m));
    run_req(1'b0, 1'b1, '1, '1, '0, '0);
    run_req(1'b1, 1'b0, '0, '0, 32'hDEAD_BEEF, 4'b1001);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule